// File: doc/BRIEF.md
# Per-Pin I/O Multiplexer with Coprocessor Lanes

This block sits between the pads of a six-bank GPIO ring (126 pins in total) and the logic that wants to use them. Every pin owns a 3-bit select register. The four low codes connect the pin to one of four ordinary peripheral function planes. The four high codes hand the pin to one of four small bit-banging coprocessor ports. Each of those ports is 28 lanes wide. For each pin the block steers the output value and the output enable from the chosen source to the pad, and it returns the pad input to that source.

Coprocessor lanes are fixed to pins by bank position. Banks B to E put local pin n on lane n. The two small banks share one lane range: bank A fills lanes 0 to 15 and bank F follows on lanes 16 to 25. Because of this, spare pins from several banks can be combined into one contiguous bus on a coprocessor port. Pad inputs bound for a coprocessor pass through a two-flop synchroniser. When more than one pin claims the same lane, the block settles it with a fixed priority and records the clash in a sticky per-port flag.

Top module: `pinmux_top`

## Requirements
- R1: After reset every select register holds 0, so every pin takes its output and output enable from function plane 0. All conflict flags read 0 and every `cop_in` bit reads 0.
- R2: A pin p with select code f in 0..3 drives `pad_out[p]` from `fn_out[f*126+p]` and `pad_oe[p]` from `fn_oe[f*126+p]`. `fn_in[f*126+p]` equals `pad_in[p]` for the selected plane and reads 0 on every plane that is not selected.
- R3: A pin with select code 4+k (k = 0..3) takes its output and output enable only from coprocessor port k, at bit `cop_out[k*28+lane]` / `cop_oe[k*28+lane]`. None of that pin's `fn_in` bits is set.
- R4: Global pin numbering is A0..A15 = 0..15, B0..B27 = 16..43, C = 44..67, D = 68..91, E = 92..115, F0..F9 = 116..125. The lane is the local pin number for banks A to E. For bank F the lane is 16 plus the local number.
- R5: `cop_in[k*28+i]` carries the synchronised input of the pin routed to port k, lane i. It reads 0 when no pin is routed there.
- R6: A change on `pad_in` of a coprocessor-routed pin shows on `cop_in` after the second rising clock edge, and not after the first.
- R7: When several pins select the same port and lane, the pin with the lowest global number (earliest bank) supplies `cop_in`.
- R8: `cop_conflict[k]` is set on the clock edge after two or more pins claim one lane of port k. It stays set until reset, even after the clash is removed. Bank A and bank F pins never clash with each other.
- R9: With `cfg_we` high at a rising edge, `cfg_wdata` is stored as the select of pin `cfg_addr`, and the routing changes right after that edge. `cfg_rdata` shows the stored select of pin `cfg_addr` without delay.
- R10: A write to an address of 126 or above changes no select register, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Select register write strobe |
| cfg_addr | input | 7 | Pin number for write and read |
| cfg_wdata | input | 3 | Select code to store |
| cfg_rdata | output | 3 | Select code of the addressed pin |
| pad_in | input | 126 | Input value from each pad |
| pad_out | output | 126 | Output value to each pad |
| pad_oe | output | 126 | Output enable to each pad |
| fn_out | input | 504 | Peripheral outputs, plane f at bits f*126 upward |
| fn_oe | input | 504 | Peripheral output enables, same layout |
| fn_in | output | 504 | Pad inputs returned to each plane, same layout |
| cop_out | input | 112 | Coprocessor outputs, port k at bits k*28 upward |
| cop_oe | input | 112 | Coprocessor output enables, same layout |
| cop_in | output | 112 | Synchronised inputs per coprocessor lane |
| cop_conflict | output | 4 | Sticky lane-clash flag per coprocessor port |

## Verification
The hardest case to reach is a lane clash between two banks. It requires two pins from different banks that share a lane number to select the same coprocessor code, and then it requires the routing to be undone again to show that the flag is sticky. The bench routes A2 and B2 both to port 0. It drives the two pads with opposite values to show which pin wins, then moves B2 back to a function and confirms that the flag stays set. A second pair, A0 and F0, both go to port 3, which shows that the concatenated banks land on separate lanes without a false clash.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

   localparam int NUM_BANKS = 6;
   // Widths of banks A..F; order defines priority and global numbering.
   localparam int BANK_WIDTH [NUM_BANKS] = '{16, 28, 24, 24, 24, 10};
   // Bank F is appended after bank A in the coprocessor lane space.
   localparam int HEAD_BANK = 0;
   localparam int TAIL_BANK = 5;

   function automatic int bank_base(input int b);
      int s;
      s = 0;
      for (int i = 0; i < NUM_BANKS; i++)
         if (i < b) s += BANK_WIDTH[i];
      return s;
   endfunction

   localparam int TOTAL_PINS = bank_base(NUM_BANKS);

   // Lane offset applied to a bank inside the coprocessor port.
   function automatic int lane_offset(input int b);
      return (b == TAIL_BANK) ? BANK_WIDTH[HEAD_BANK] : 0;
   endfunction

   // Coprocessor lane of a global pin number.
   function automatic int lane_of_pin(input int p);
      int r;
      r = 0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (p >= bank_base(b) && p < bank_base(b) + BANK_WIDTH[b])
            r = p - bank_base(b) + lane_offset(b);
      return r;
   endfunction

   // Global pin of bank b that feeds lane i, or -1 if none.
   function automatic int pin_of_lane(input int b, input int i);
      int loc;
      loc = i - lane_offset(b);
      return (loc >= 0 && loc < BANK_WIDTH[b]) ? bank_base(b) + loc : -1;
   endfunction

   // Highest lane any bank reaches, plus one.
   function automatic int lanes_needed();
      int m;
      m = 0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (BANK_WIDTH[b] + lane_offset(b) > m) m = BANK_WIDTH[b] + lane_offset(b);
      return m;
   endfunction

endpackage

// File: rtl/pinmux_selbank.sv
module pinmux_selbank #(
   parameter int NPIN  = 126,
   parameter int SEL_W = 3,
   parameter int AW    = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [AW-1:0]         addr,
   input  logic [SEL_W-1:0]      wdata,
   output logic [SEL_W-1:0]      rdata,
   output logic [NPIN*SEL_W-1:0] sel_flat
);

   logic [SEL_W-1:0] sel_q [NPIN];

   for (genvar p = 0; p < NPIN; p++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q[p] <= '0;
         else if (we && addr == AW'(p))
            sel_q[p] <= wdata;
      end
      assign sel_flat[p*SEL_W +: SEL_W] = sel_q[p];
   end

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NPIN; p++)
         if (addr == AW'(p)) rdata = sel_q[p];
   end

endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
   parameter int W      = 126,
   parameter int NSTAGE = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (NSTAGE < 1) begin : g_bad
      $error("pinmux_sync: NSTAGE must be at least 1");
   end

   logic [W-1:0] stage [NSTAGE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSTAGE; s++) stage[s] <= '0;
      end else begin
         stage[0] <= d;
         for (int s = 1; s < NSTAGE; s++) stage[s] <= stage[s-1];
      end
   end

   assign q = stage[NSTAGE-1];

endmodule

// File: rtl/pinmux_outroute.sv
module pinmux_outroute
   import pinmux_pkg::*;
#(
   parameter int NPIN     = 126,
   parameter int SEL_W    = 3,
   parameter int NUM_FUNC = 4,
   parameter int NUM_COP  = 4,
   parameter int COP_W    = 28
) (
   input  logic [NPIN*SEL_W-1:0]     sel_flat,
   input  logic [NPIN-1:0]           pad_in,
   output logic [NPIN-1:0]           pad_out,
   output logic [NPIN-1:0]           pad_oe,
   input  logic [NUM_FUNC*NPIN-1:0]  fn_out,
   input  logic [NUM_FUNC*NPIN-1:0]  fn_oe,
   output logic [NUM_FUNC*NPIN-1:0]  fn_in,
   input  logic [NUM_COP*COP_W-1:0]  cop_out,
   input  logic [NUM_COP*COP_W-1:0]  cop_oe
);

   localparam int NSRC = NUM_FUNC + NUM_COP;

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      localparam int LANE = lane_of_pin(p);
      logic [SEL_W-1:0] sel;
      logic [NSRC-1:0]  hit, src_o, src_e;

      assign sel = sel_flat[p*SEL_W +: SEL_W];

      for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
         assign hit[f]   = (sel == SEL_W'(f));
         assign src_o[f] = fn_out[f*NPIN + p];
         assign src_e[f] = fn_oe[f*NPIN + p];
         assign fn_in[f*NPIN + p] = hit[f] & pad_in[p];
      end

      for (genvar k = 0; k < NUM_COP; k++) begin : g_cop
         assign hit[NUM_FUNC+k]   = (sel == SEL_W'(NUM_FUNC + k));
         assign src_o[NUM_FUNC+k] = cop_out[k*COP_W + LANE];
         assign src_e[NUM_FUNC+k] = cop_oe[k*COP_W + LANE];
      end

      // AND-OR selection: a code that names no source yields 0 on both.
      assign pad_out[p] = |(hit & src_o);
      assign pad_oe[p]  = |(hit & src_e);
   end

endmodule

// File: rtl/pinmux_coproute.sv
module pinmux_coproute
   import pinmux_pkg::*;
#(
   parameter int NPIN     = 126,
   parameter int SEL_W    = 3,
   parameter int NUM_FUNC = 4,
   parameter int NUM_COP  = 4,
   parameter int COP_W    = 28
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPIN*SEL_W-1:0]    sel_flat,
   input  logic [NPIN-1:0]          sync_in,
   output logic [NUM_COP*COP_W-1:0] cop_in,
   output logic [NUM_COP-1:0]       conflict
);

   logic [NPIN-1:0]    claims [NUM_COP];
   logic [COP_W-1:0]   clash  [NUM_COP];
   logic [NUM_COP-1:0] clash_any;

   for (genvar k = 0; k < NUM_COP; k++) begin : g_port
      for (genvar p = 0; p < NPIN; p++) begin : g_claim
         assign claims[k][p] = (sel_flat[p*SEL_W +: SEL_W] == SEL_W'(NUM_FUNC + k));
      end

      for (genvar i = 0; i < COP_W; i++) begin : g_lane
         logic [NUM_BANKS-1:0] cand, val;
         for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int PIN = pin_of_lane(b, i);
            if (PIN >= 0) begin : g_hit
               assign cand[b] = claims[k][PIN];
               assign val[b]  = sync_in[PIN];
            end else begin : g_none
               assign cand[b] = 1'b0;
               assign val[b]  = 1'b0;
            end
         end

         // Lowest bank (lowest global pin) has priority.
         always_comb begin
            cop_in[k*COP_W + i] = 1'b0;
            for (int b = NUM_BANKS - 1; b >= 0; b--)
               if (cand[b]) cop_in[k*COP_W + i] = val[b];
         end

         assign clash[k][i] = (cand & (cand - 1'b1)) != '0;
      end

      assign clash_any[k] = |clash[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) conflict <= '0;
      else        conflict <= conflict | clash_any;
   end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
   import pinmux_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int NUM_FUNC = 4,
   parameter int NUM_COP  = 4,
   parameter int COP_W    = 28,
   parameter int NSYNC    = 2,
   localparam int NPIN    = TOTAL_PINS,
   localparam int AW      = $clog2(NPIN)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [AW-1:0]             cfg_addr,
   input  logic [SEL_W-1:0]          cfg_wdata,
   output logic [SEL_W-1:0]          cfg_rdata,
   input  logic [NPIN-1:0]           pad_in,
   output logic [NPIN-1:0]           pad_out,
   output logic [NPIN-1:0]           pad_oe,
   input  logic [NUM_FUNC*NPIN-1:0]  fn_out,
   input  logic [NUM_FUNC*NPIN-1:0]  fn_oe,
   output logic [NUM_FUNC*NPIN-1:0]  fn_in,
   input  logic [NUM_COP*COP_W-1:0]  cop_out,
   input  logic [NUM_COP*COP_W-1:0]  cop_oe,
   output logic [NUM_COP*COP_W-1:0]  cop_in,
   output logic [NUM_COP-1:0]        cop_conflict
);

   if (NUM_FUNC + NUM_COP > (1 << SEL_W)) begin : g_chk_codes
      $error("pinmux_top: select field too narrow for all sources");
   end
   if (lanes_needed() > COP_W) begin : g_chk_lanes
      $error("pinmux_top: coprocessor port narrower than bank lane map");
   end
   if (NSYNC < 2) begin : g_chk_sync
      $error("pinmux_top: synchroniser needs at least two stages");
   end

   logic [NPIN*SEL_W-1:0] sel_flat;
   logic [NPIN-1:0]       sync_in;

   pinmux_selbank #(.NPIN(NPIN), .SEL_W(SEL_W), .AW(AW)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .sel_flat (sel_flat)
   );

   pinmux_outroute #(.NPIN(NPIN), .SEL_W(SEL_W), .NUM_FUNC(NUM_FUNC),
                     .NUM_COP(NUM_COP), .COP_W(COP_W)) u_out (
      .sel_flat (sel_flat),
      .pad_in   (pad_in),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe),
      .fn_out   (fn_out),
      .fn_oe    (fn_oe),
      .fn_in    (fn_in),
      .cop_out  (cop_out),
      .cop_oe   (cop_oe)
   );

   pinmux_sync #(.W(NPIN), .NSTAGE(NSYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_in)
   );

   pinmux_coproute #(.NPIN(NPIN), .SEL_W(SEL_W), .NUM_FUNC(NUM_FUNC),
                     .NUM_COP(NUM_COP), .COP_W(COP_W)) u_cop (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_flat (sel_flat),
      .sync_in  (sync_in),
      .cop_in   (cop_in),
      .conflict (cop_conflict)
   );

endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk #(
   parameter int SEL_W    = 3,
   parameter int NUM_FUNC = 4,
   parameter int NUM_COP  = 4,
   parameter int AW       = 7,
   parameter int NPIN     = 126
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [AW-1:0]      cfg_addr,
   input logic [SEL_W-1:0]   cfg_wdata,
   input logic [SEL_W-1:0]   cfg_rdata,
   input logic               pin0_out,
   input logic               pin0_oe,
   input logic               fn0_out,
   input logic               fn0_oe,
   input logic               cop0_out,
   input logic               cop0_oe,
   input logic [NUM_COP-1:0] conflict
);

   // R2
   fn_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == '0 && cfg_wdata == '0)
      |=> (pin0_out == fn0_out && pin0_oe == fn0_oe));

   // R3
   cop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == '0 && cfg_wdata == SEL_W'(NUM_FUNC))
      |=> (pin0_out == cop0_out && pin0_oe == cop0_oe));

   // R8
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conflict != '0) |=> ((conflict & $past(conflict)) == $past(conflict)));

   // R9
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_addr) < NPIN)
      |=> (cfg_addr != $past(cfg_addr) || cfg_rdata == $past(cfg_wdata)));

endmodule

bind pinmux_top pinmux_chk #(
   .SEL_W(SEL_W), .NUM_FUNC(NUM_FUNC), .NUM_COP(NUM_COP), .AW(AW), .NPIN(NPIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .pin0_out  (pad_out[0]),
   .pin0_oe   (pad_oe[0]),
   .fn0_out   (fn_out[0]),
   .fn0_oe    (fn_oe[0]),
   .cop0_out  (cop_out[0]),
   .cop0_oe   (cop_oe[0]),
   .conflict  (cop_conflict)
);

// File: tb/pinmux_top_test.sv
module pinmux_top_test;

   localparam int NPIN = 126;
   localparam int NF   = 4;
   localparam int NC   = 4;
   localparam int CW   = 28;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [6:0]        cfg_addr = '0;
   logic [2:0]        cfg_wdata = '0;
   logic [2:0]        cfg_rdata;
   logic [NPIN-1:0]   pad_in = '0;
   logic [NPIN-1:0]   pad_out, pad_oe;
   logic [NF*NPIN-1:0] fn_out = '0, fn_oe = '0;
   logic [NF*NPIN-1:0] fn_in;
   logic [NC*CW-1:0]  cop_out = '0, cop_oe = '0;
   logic [NC*CW-1:0]  cop_in;
   logic [NC-1:0]     cop_conflict;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pinmux_top uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .fn_out(fn_out), .fn_oe(fn_oe),
      .fn_in(fn_in), .cop_out(cop_out), .cop_oe(cop_oe), .cop_in(cop_in),
      .cop_conflict(cop_conflict)
   );

   // Lane of a global pin, from the bank layout in R4.
   function automatic int exp_lane(input int p);
      if (p < 16)  return p;
      if (p < 44)  return p - 16;
      if (p < 68)  return p - 44;
      if (p < 92)  return p - 68;
      if (p < 116) return p - 92;
      return p - 116 + 16;
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_sel(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = 3'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
   endtask

   // {pin[6:0], code[2:0]}
   localparam logic [9:0] VEC [12] = '{
      {7'd0,   3'd0}, {7'd5,   3'd1}, {7'd20,  3'd2}, {7'd50,  3'd3},
      {7'd3,   3'd4}, {7'd43,  3'd5}, {7'd60,  3'd6}, {7'd117, 3'd7},
      {7'd125, 3'd4}, {7'd92,  3'd5}, {7'd80,  3'd6}, {7'd15,  3'd7}
   };

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      cfg_addr = 7'd0;   #1 check("R1 sel pin0", 128'(cfg_rdata), 128'd0);
      cfg_addr = 7'd63;  #1 check("R1 sel pin63", 128'(cfg_rdata), 128'd0);
      cfg_addr = 7'd125; #1 check("R1 sel pin125", 128'(cfg_rdata), 128'd0);
      fn_oe[NPIN-1:0] = '1; cop_oe = '1; #1
      check("R1 oe plane0", 128'(pad_oe), {2'b0, {NPIN{1'b1}}});
      fn_oe = '0; cop_oe = '0;
      pad_in = '1;
      repeat (3) @(negedge clk);
      check("R1 cop_in idle", 128'(cop_in), 128'd0);
      check("R1 conflict", 128'(cop_conflict), 128'd0);
      pad_in = '0;

      // Table walk: R2, R3, R4, R5, R9
      for (int v = 0; v < 12; v++) begin
         int p, c, k, l;
         logic [NC*CW-1:0] want;
         p = int'(VEC[v][9:3]); c = int'(VEC[v][2:0]);
         write_sel(p, c);
         cfg_addr = 7'(p); #1
         check("R9 readback", 128'(cfg_rdata), 128'(c));
         if (c < NF) begin
            fn_out = '0; fn_oe = '0; cop_out = '1; cop_oe = '1;
            fn_out[c*NPIN+p] = 1'b1; fn_oe[c*NPIN+p] = 1'b1; #1
            check("R2 out high", 128'({pad_out[p], pad_oe[p]}), 128'd3);
            fn_out = '1; fn_oe = '1; cop_out = '0; cop_oe = '0;
            fn_out[c*NPIN+p] = 1'b0; fn_oe[c*NPIN+p] = 1'b0; #1
            check("R2 out low", 128'({pad_out[p], pad_oe[p]}), 128'd0);
            pad_in[p] = 1'b1; #1
            check("R2 fn_in bit", 128'(fn_in[c*NPIN+p]), 128'd1);
            check("R2 fn_in count", 128'($countones(fn_in)), 128'd1);
         end else begin
            k = c - NF; l = exp_lane(p);
            cop_out = '0; cop_oe = '0; fn_out = '1; fn_oe = '1;
            cop_out[k*CW+l] = 1'b1; cop_oe[k*CW+l] = 1'b1; #1
            check("R3 R4 out high", 128'({pad_out[p], pad_oe[p]}), 128'd3);
            cop_out = '1; cop_oe = '1; fn_out = '0; fn_oe = '0;
            cop_out[k*CW+l] = 1'b0; cop_oe[k*CW+l] = 1'b0; #1
            check("R3 R4 out low", 128'({pad_out[p], pad_oe[p]}), 128'd0);
            pad_in[p] = 1'b1;
            repeat (3) @(negedge clk);
            want = '0; want[k*CW+l] = 1'b1;
            check("R5 lane input", 128'(cop_in), 128'(want));
            check("R3 no fn_in", 128'($countones(fn_in)), 128'd0);
         end
         pad_in = '0; fn_out = '0; fn_oe = '0; cop_out = '0; cop_oe = '0;
         write_sel(p, 0);
         repeat (2) @(negedge clk);
      end

      // R5: no pin on any lane reads 0
      check("R5 empty lanes", 128'(cop_in), 128'd0);

      // R9: write takes effect only after the edge
      fn_out = '0; fn_out[5] = 1'b1;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 7'd5; cfg_wdata = 3'd1; #1
      check("R9 before edge", 128'(pad_out[5]), 128'd1);
      @(negedge clk); cfg_we = 1'b0; #1
      check("R9 after edge", 128'(pad_out[5]), 128'd0);
      fn_out = '0;
      write_sel(5, 0);

      // R10: out-of-range address
      write_sel(0, 7);
      write_sel(126, 5);
      write_sel(127, 6);
      cfg_addr = 7'd126; #1 check("R10 read 126", 128'(cfg_rdata), 128'd0);
      cfg_addr = 7'd0;   #1 check("R10 pin0 kept", 128'(cfg_rdata), 128'd7);
      cfg_addr = 7'd125; #1 check("R10 pin125 kept", 128'(cfg_rdata), 128'd0);

      // R8: A0 and F0 share port 3 without clash; R6 sync latency
      write_sel(116, 7);
      repeat (2) @(negedge clk);
      check("R8 A/F no clash", 128'(cop_conflict), 128'd0);
      pad_in[116] = 1'b1;
      @(negedge clk); #1
      check("R6 one edge", 128'(cop_in[3*CW+16]), 128'd0);
      @(negedge clk); #1
      check("R6 two edges", 128'(cop_in[3*CW+16]), 128'd1);
      pad_in[0] = 1'b1;
      repeat (3) @(negedge clk);
      check("R4 A0 and F0 lanes", 128'({cop_in[3*CW+16], cop_in[3*CW+0]}), 128'd3);
      pad_in = '0;
      write_sel(0, 0);
      write_sel(116, 0);

      // R7 / R8: A2 and B2 both on port 0 lane 2
      write_sel(2, 4);
      write_sel(18, 4);
      @(negedge clk); #1
      check("R8 clash flag", 128'(cop_conflict), 128'd1);
      pad_in[2] = 1'b1; pad_in[18] = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 A wins high", 128'(cop_in[2]), 128'd1);
      pad_in[2] = 1'b0; pad_in[18] = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 A wins low", 128'(cop_in[2]), 128'd0);
      write_sel(18, 0);
      repeat (3) @(negedge clk);
      check("R8 sticky", 128'(cop_conflict), 128'd1);
      pad_in = '0;

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule